// File: doc/BRIEF.md
# Successive-Approximation Converter Control Logic

This block is the digital half of an 8-bit successive-approximation converter that hangs off a small microcontroller bus. Software programs a control register with a channel code, an enable bit and a clock-source bit. The block then drives the channel code to an external analog multiplexer and pulses a sample strobe so that the selected level is captured. After that it presents one binary-weighted trial code per cycle to an external capacitor DAC, and it reads back a single comparator bit that says whether the held input lies below the DAC level.

After eight trials the resolved code moves into a read-only result register and a completion flag rises. The block then samples the same channel again and keeps converting, so the result register always tracks the input. A write to the control register abandons the conversion in progress, drops the flag and starts over at once on the channel just written. The eight channel codes cover four external pins and four internal reference points (high reference, low reference, a quarter of their sum, half of their sum). The reference points are useful for checking the converter.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00: channel 0, clock-source bit 0, enable bit 0 and completion flag 0. The result register reads 0x00, `sample_o` is low and `dac_code` is 0x00.
- R2: The control register sits at address `CTRL_ADDR` and the result register at `CTRL_ADDR+1`. In the control register, bits 2:0 hold the channel, bit 4 the clock source, bit 5 the enable and bit 7 the completion flag; bits 3 and 6 read 0. Any other address, or a cycle with `bus_sel` low, reads 0x00. `clk_src_o` follows control bit 4.
- R3: A control write with bit 5 set raises `sample_o` for exactly the one cycle after the write edge. During that cycle `mux_sel` equals the channel just written.
- R4: The trial phase starts with `dac_code` = 0x80. Each trial sets the current bit on top of the bits already resolved. That bit is cleared when `cmp_below` is 1 and kept when it is 0, and the next trial moves one bit lower.
- R5: The result register loads and the completion flag rises on the 9th rising edge after the control write (one sample cycle plus eight trials). The flag is still 0 after the 8th edge.
- R6: The result is the largest code whose DAC level does not exceed the sampled input, for every channel code 0 through 7.
- R7: After a conversion completes, the block samples the same channel again and converts continuously. The result register updates every 9 cycles while the completion flag stays at 1.
- R8: A control write during a conversion clears the completion flag on the write edge, abandons the partial result and starts a fresh sample on the newly written channel.
- R9: While the enable bit is 0, `sample_o` stays low, `dac_code` stays 0x00 and the result register keeps its last value.
- R10: Writes to the result register change neither register. Reading the result register does not clear the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access to this block in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| mux_sel | output | 3 | Channel code to the analog multiplexer |
| dac_code | output | 8 | Trial code to the capacitor DAC |
| sample_o | output | 1 | Sample strobe, one cycle at the start of each conversion |
| cmp_below | input | 1 | Comparator: held input is below the DAC level |
| clk_src_o | output | 1 | Conversion clock-source selection |

## Verification
The hardest case to reach is an abort that lands partway through the trials while the completion flag is already set. Reaching it needs one full conversion, then the continuous restart, and then a control write timed a few cycles into the next trial phase. The bench does this with directed writes counted in edges from a known write. It checks the partial trial codes before the abort and the flag clearing on the abort edge. It then checks that the result comes from the new channel's level. The bench models the comparator with a sample-and-hold register that captures the channel's level on the strobe edge, so a level change after the strobe must not reach the result.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  localparam int unsigned CHAN_W     = 3;
  localparam int unsigned CTL_CLK_B  = 4;
  localparam int unsigned CTL_EN_B   = 5;
  localparam int unsigned CTL_DONE_B = 7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sar_adc_rst_sync.sv
module sar_adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h20
) (
  input  logic                clk,
  input  logic                rst_sn,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                res_load,
  input  logic [DATA_W-1:0]   res_value,
  output logic                ctrl_wr,
  output logic                data_wr,
  output logic [CHAN_W-1:0]   chan,
  output logic                clk_sel,
  output logic                done
);

  localparam logic [ADDR_W-1:0] DATA_ADDR = CTRL_ADDR + 1'b1;

  logic [CHAN_W-1:0] chan_q, chan_n;
  logic              en_q, en_n;
  logic              clk_q, clk_n;
  logic              done_q, done_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic [DATA_W-1:0] ctl_view;

  assign ctrl_wr = bus_sel && bus_we && (bus_addr == CTRL_ADDR);
  assign data_wr = bus_sel && bus_we && (bus_addr == DATA_ADDR);

  // Next-state: control write wins over completion on the same edge
  always_comb begin
    chan_n = chan_q;
    en_n   = en_q;
    clk_n  = clk_q;
    done_n = done_q;
    data_n = data_q;
    if (res_load) begin
      data_n = res_value;
      done_n = 1'b1;
    end
    if (ctrl_wr) begin
      chan_n = bus_wdata[CHAN_W-1:0];
      clk_n  = bus_wdata[CTL_CLK_B];
      en_n   = bus_wdata[CTL_EN_B];
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      chan_q <= '0;
      en_q   <= 1'b0;
      clk_q  <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      chan_q <= chan_n;
      en_q   <= en_n;
      clk_q  <= clk_n;
      done_q <= done_n;
      data_q <= data_n;
    end
  end

  always_comb begin
    ctl_view                = '0;
    ctl_view[CHAN_W-1:0]    = chan_q;
    ctl_view[CTL_CLK_B]     = clk_q;
    ctl_view[CTL_EN_B]      = en_q;
    ctl_view[CTL_DONE_B]    = done_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == CTRL_ADDR)      bus_rdata = ctl_view;
      else if (bus_addr == DATA_ADDR) bus_rdata = data_q;
    end
  end

  assign chan    = chan_q;
  assign clk_sel = clk_q;
  assign done    = done_q;

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             restart,
  input  logic             en_new,
  input  logic             cmp_below,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_code,
  output logic             res_load,
  output logic [RES_W-1:0] res_value
);

  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  seq_state_e       state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [RES_W-1:0] sar_q, sar_n;
  logic [RES_W-1:0] bit_mask;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] kept;

  assign bit_mask = RES_W'(1) << idx_q;
  assign trial    = sar_q | bit_mask;
  assign kept     = cmp_below ? (trial & ~bit_mask) : trial;

  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    sar_n     = sar_q;
    res_load  = 1'b0;
    res_value = kept;
    unique case (state_q)
      ST_IDLE: ;
      ST_SAMPLE: begin
        state_n = ST_TRIAL;
        idx_n   = TOP_IDX;
        sar_n   = '0;
      end
      ST_TRIAL: begin
        sar_n = kept;
        if (idx_q == '0) begin
          res_load = 1'b1;
          state_n  = ST_SAMPLE;
        end else begin
          idx_n = idx_q - IDX_W'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (restart) begin
      state_n  = en_new ? ST_SAMPLE : ST_IDLE;
      res_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sar_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      sar_q   <= sar_n;
    end
  end

  assign sample_o = (state_q == ST_SAMPLE);
  assign dac_code = (state_q == ST_TRIAL) ? trial : '0;

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h20,
  parameter int unsigned RES_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [2:0]        mux_sel,
  output logic [RES_W-1:0]  dac_code,
  output logic              sample_o,
  input  logic              cmp_below,
  output logic              clk_src_o
);

  logic              rst_sn;
  logic              ctrl_wr;
  logic              data_wr;
  logic              done;
  logic              res_load;
  logic [RES_W-1:0]  res_value;
  logic [CHAN_W-1:0] chan;

  sar_adc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  sar_adc_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (RES_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .res_load  (res_load),
    .res_value (res_value),
    .ctrl_wr   (ctrl_wr),
    .data_wr   (data_wr),
    .chan      (chan),
    .clk_sel   (clk_src_o),
    .done      (done)
  );

  sar_adc_seq #(.RES_W(RES_W)) u_seq (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .restart   (ctrl_wr),
    .en_new    (bus_wdata[CTL_EN_B]),
    .cmp_below (cmp_below),
    .sample_o  (sample_o),
    .dac_code  (dac_code),
    .res_load  (res_load),
    .res_value (res_value)
  );

  assign mux_sel = chan;

endmodule

// File: rtl/sar_adc_chk.sv
module sar_adc_chk #(
  parameter int unsigned RES_W = 8
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             ctrl_wr,
  input logic             data_wr,
  input logic             en_bit,
  input logic             done,
  input logic             sample_o,
  input logic [RES_W-1:0] dac_code,
  input logic             res_load,
  input logic [7:0]       bus_wdata
);

  // R3
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ctrl_wr && bus_wdata[5]) |=> sample_o);

  // R4
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (sample_o && !ctrl_wr) |=> (dac_code == {1'b1, {(RES_W-1){1'b0}}}));

  // R8
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ctrl_wr |=> !done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!en_bit && !$past(ctrl_wr)) |-> (!sample_o && dac_code == '0));

  // R10
  data_ro_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (data_wr && !res_load && done) |=> done);

  // R5
  load_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (res_load && !ctrl_wr) |=> done);

endmodule

bind sar_adc_ctrl sar_adc_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .ctrl_wr   (ctrl_wr),
  .data_wr   (data_wr),
  .en_bit    (u_regs.en_q),
  .done      (done),
  .sample_o  (sample_o),
  .dac_code  (dac_code),
  .res_load  (res_load),
  .bus_wdata (bus_wdata)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;

  localparam logic [7:0] CA = 8'h20;
  localparam logic [7:0] DA = 8'h21;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_we;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0] mux_sel;
  logic [7:0] dac_code;
  logic       sample_o, cmp_below, clk_src_o;

  int n_chk = 0;
  int n_err = 0;
  int n_samp = 0;
  int ext_lvl [4];
  int held;

  always #5 clk = ~clk;

  sar_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mux_sel(mux_sel), .dac_code(dac_code), .sample_o(sample_o),
    .cmp_below(cmp_below), .clk_src_o(clk_src_o)
  );

  // Analog model: levels in quarter-LSB units, 0..1023
  function automatic int src_level(input logic [2:0] ch);
    case (ch)
      3'd4:    return 1023;
      3'd5:    return 0;
      3'd6:    return (1023 + 0) / 4;
      3'd7:    return (1023 + 0) / 2;
      default: return ext_lvl[ch[1:0]];
    endcase
  endfunction

  function automatic int exp_code(input int lvl);
    return (lvl / 4 > 255) ? 255 : lvl / 4;
  endfunction

  always @(posedge clk) begin
    if (sample_o) begin
      held <= src_level(mux_sel);
      n_samp <= n_samp + 1;
    end
  end
  assign cmp_below = (held < int'(dac_code) * 4);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // {channel, level}
  localparam logic [12:0] VEC [10] = '{
    {3'd0, 10'd0},   {3'd1, 10'd1023}, {3'd2, 10'd514}, {3'd3, 10'd509},
    {3'd4, 10'd0},   {3'd5, 10'd0},    {3'd6, 10'd0},   {3'd7, 10'd0},
    {3'd3, 10'd4},   {3'd2, 10'd3}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0;
    for (int i = 0; i < 4; i++) ext_lvl[i] = 0;
    held = 0;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    rd(CA, v); check("R1 ctrl", v, 8'h00);
    rd(DA, v); check("R1 data", v, 8'h00);
    check("R1 sample", sample_o, 0);
    check("R1 dac", dac_code, 0);

    // R6 / R5 vector walk
    foreach (VEC[k]) begin
      logic [2:0] ch;
      ch = VEC[k][12:10];
      if (ch < 3'd4) ext_lvl[ch[1:0]] = int'(VEC[k][9:0]);
      wr(CA, 8'h20 | {5'd0, ch});
      repeat (8) @(posedge clk);
      @(negedge clk);
      rd(CA, v); check("R5 flag low at edge 8", v[7], 0);
      @(posedge clk);
      @(negedge clk);
      rd(CA, v); check("R5 flag at edge 9", v[7], 1);
      rd(DA, v); check($sformatf("R6 result ch%0d", ch), v, exp_code(src_level(ch)));
    end

    // R2 readback and clock source
    rd(CA, v); check("R2 ctrl layout", v, 8'hA2);
    wr(CA, 8'h35);
    @(negedge clk);
    check("R2 clk_src_o", clk_src_o, 1);
    rd(CA, v); check("R2 readback", v & 8'h7F, 8'h35);
    rd(8'h22, v); check("R2 unmapped", v, 0);
    bus_addr = CA; #1; check("R2 no sel", bus_rdata, 0);

    // R7 continuous conversion
    ext_lvl[2] = 514;
    wr(CA, 8'h22);
    repeat (9) @(posedge clk);
    @(negedge clk);
    ext_lvl[2] = 800;
    repeat (18) @(posedge clk);
    @(negedge clk);
    rd(DA, v); check("R7 tracks input", v, 200);
    rd(CA, v); check("R10 flag kept after data read", v[7], 1);
    check("R7 still on channel", mux_sel, 2);

    // R3 / R4 / R8 abort mid-trial
    ext_lvl[0] = 400;
    ext_lvl[1] = 40;
    wr(CA, 8'h20);
    rd(CA, v); check("R8 flag cleared", v[7], 0);
    check("R3 strobe", sample_o, 1);
    check("R3 channel", mux_sel, 0);
    @(posedge clk); @(negedge clk);
    check("R3 strobe one cycle", sample_o, 0);
    check("R4 first trial", dac_code, 8'h80);
    @(posedge clk); @(negedge clk);
    check("R4 second trial", dac_code, 8'h40);
    wr(CA, 8'h21);
    rd(CA, v); check("R8 flag after abort", v[7], 0);
    check("R8 restart strobe", sample_o, 1);
    check("R8 new channel", mux_sel, 1);
    repeat (9) @(posedge clk);
    @(negedge clk);
    rd(DA, v); check("R8 new result", v, 10);

    // R9 disable
    wr(CA, 8'h10);
    @(negedge clk);
    s0 = n_samp;
    ext_lvl[1] = 900;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R9 no samples", n_samp - s0, 0);
    check("R9 dac idle", dac_code, 0);
    rd(DA, v); check("R9 data held", v, 10);
    rd(CA, v); check("R9 ctrl", v, 8'h10);

    // R10 data register ignores writes
    wr(DA, 8'h55);
    @(negedge clk);
    rd(DA, v); check("R10 data unchanged", v, 10);
    rd(CA, v); check("R10 ctrl unchanged", v, 8'h10);

    // R1 reset again mid-run
    wr(CA, 8'h23);
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    rd(CA, v); check("R1 ctrl after reset", v, 0);
    rd(DA, v); check("R1 data after reset", v, 0);
    check("R1 clk_src after reset", clk_src_o, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule